// File: doc/BRIEF.md
# Linear One-Hot Step Sequencer

This block is a controller that walks once through a fixed, straight-line series of steps. Each step has its own flip-flop. The step register is a plain shift chain, so the block has no next-state decoder. A single hot bit enters at the top of the chain and moves one stage toward the bottom on every clock. After the last stage it drops off the end, and the chain then holds all zeros, which is the idle state. The hot bit never wraps around the way it would in a ring counter.

A synchronous, active-high reset loads the first step. A start pulse loads the first step again, but only when the chain is idle. A start pulse that arrives while a step is active is ignored. A done flag reports the idle state. The surrounding logic takes the individual step bits as enables for a sequence of actions.

Top module: `step_chain_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `step_vec` becomes the first step on that edge. The first step is the vector with only bit `NUM_STEPS-1` set, which is `1000` for the default of 4.
- R2: While the chain is active and `rst` is low, each rising edge shifts `step_vec` one position toward bit 0, and a 0 enters bit `NUM_STEPS-1`. With the default width the sequence is `1000`, `0100`, `0010`, `0001`, `0000`.
- R3: Once `step_vec` is all zeros, it stays all zeros on every edge until `rst` is high or `start` is high.
- R4: If `start` is high at an edge while `step_vec` is all zeros and `rst` is low, `step_vec` becomes the first step on that edge.
- R5: If `start` is high while `step_vec` is not all zeros, the next value of `step_vec` is the same as it would be with `start` low.
- R6: `done` is a combinational output that is high exactly when `step_vec` is all zeros and `rst` is low.
- R7: After the first reset, `step_vec` always has at most one bit set.
- R8: When `rst` and `start` are high together, reset wins and the first step is loaded. This holds both while the chain is active and while it is idle.
- R9: The number of steps is the parameter `NUM_STEPS` (default 4, minimum 2). The state uses exactly `NUM_STEPS` flip-flops. A smaller value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the first step |
| start | input | 1 | Relaunch request; takes effect only when the chain is idle |
| step_vec | output | NUM_STEPS | One-hot step vector; bit NUM_STEPS-1 is the first step |
| done | output | 1 | High when the chain is idle and reset is low |

## Verification
The hardest situation to reach is the boundary between the last step and idle. A start pulse that arrives one cycle too early, while only bit 0 is set, must be dropped. A start pulse one cycle later must relaunch the chain. The stimulus reaches this boundary by holding `start` high for several whole passes, so that every relaunch happens on the first idle cycle. It also places single start pulses on the last active step and on the step just before it. Reset and start are also driven together, once mid-sequence and once while idle, to show that reset has priority in both cases.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
   // smallest chain that still has a distinct first and last step
   localparam int unsigned STEP_MIN = 2;

   // value a stage takes under reset: only the head stage is hot
   function automatic bit stage_reset_bit(input int unsigned idx, input int unsigned n);
      return (idx == n - 1);
   endfunction
endpackage

// File: rtl/step_stage.sv
module step_stage #(
   parameter bit RESET_BIT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RESET_BIT;
      else     q <= d;
   end
endmodule

// File: rtl/step_chain.sv
module step_chain #(
   parameter int unsigned NUM_STEPS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 head_in,
   output logic [NUM_STEPS-1:0] chain_q
);
   localparam int unsigned HEAD = NUM_STEPS - 1;

   for (genvar i = 0; i < NUM_STEPS; i++) begin : g_stage
      logic d_i;
      if (i == HEAD) begin : g_head
         assign d_i = head_in;
      end else begin : g_body
         assign d_i = chain_q[i+1];
      end
      step_stage #(
         .RESET_BIT(step_seq_pkg::stage_reset_bit(i, NUM_STEPS))
      ) u_stage (
         .clk (clk),
         .rst (rst),
         .d   (d_i),
         .q   (chain_q[i])
      );
   end
endmodule

// File: rtl/step_idle_detect.sv
module step_idle_detect #(
   parameter int unsigned NUM_STEPS = 4
) (
   input  logic [NUM_STEPS-1:0] vec,
   input  logic                 rst,
   output logic                 idle,
   output logic                 done
);
   assign idle = ~|vec;
   assign done = idle & ~rst;
endmodule

// File: rtl/step_chain_seq.sv
module step_chain_seq #(
   parameter int unsigned NUM_STEPS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   output logic [NUM_STEPS-1:0] step_vec,
   output logic                 done
);
   if (NUM_STEPS < step_seq_pkg::STEP_MIN) begin : g_bad_width
      $error("step_chain_seq: NUM_STEPS must be at least %0d", step_seq_pkg::STEP_MIN);
   end

   logic idle;
   logic head_in;

   // only the head stage sees start; every other stage is a bare shift
   assign head_in = start & idle;

   step_chain #(.NUM_STEPS(NUM_STEPS)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .head_in (head_in),
      .chain_q (step_vec)
   );

   step_idle_detect #(.NUM_STEPS(NUM_STEPS)) u_idle (
      .vec  (step_vec),
      .rst  (rst),
      .idle (idle),
      .done (done)
   );
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
   parameter int unsigned NUM_STEPS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 start,
   input logic [NUM_STEPS-1:0] step_vec,
   input logic                 done
);
   localparam logic [NUM_STEPS-1:0] FIRST = {1'b1, {(NUM_STEPS-1){1'b0}}};
   localparam logic [NUM_STEPS-1:0] ZERO  = '0;

   p_reset_load_r1: assert property (@(posedge clk)
      rst |=> step_vec == FIRST);

   p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      (step_vec != ZERO) |=> step_vec == ($past(step_vec) >> 1));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (step_vec == ZERO && !start) |=> step_vec == ZERO);

   p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
      (step_vec == ZERO && start) |=> step_vec == FIRST);

   p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
      (step_vec != ZERO && start) |=> !step_vec[NUM_STEPS-1]);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
      done == (step_vec == ZERO));

   p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(step_vec));

   p_reset_wins_r8: assert property (@(posedge clk)
      (rst && start) |=> step_vec == FIRST);
endmodule

bind step_chain_seq step_seq_chk #(.NUM_STEPS(NUM_STEPS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .step_vec (step_vec),
   .done     (done)
);

// File: tb/tb_step_chain_seq.sv
module tb_step_chain_seq;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [N-1:0] step_vec;
   logic         done;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural model: position of the hot bit, N means idle
   int  pos = N;
   bit  model_valid = 1'b0;

   always #2 clk = ~clk;

   step_chain_seq #(.NUM_STEPS(N)) dut (
      .clk(clk), .rst(rst), .start(start), .step_vec(step_vec), .done(done)
   );

   function automatic logic [N-1:0] expect_vec(int p);
      logic [N-1:0] v = '0;
      if (p < N) v[N-1-p] = 1'b1;
      return v;
   endfunction

   task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // drive at the falling edge, check done, clock, then compare state
   task automatic tick(logic r, logic s, string tag);
      @(negedge clk);
      rst = r;
      start = s;
      #1;
      if (model_valid) check("R6 done", {{(N-1){1'b0}}, done}, {{(N-1){1'b0}}, (pos == N) && !r});
      @(posedge clk);
      if (r)             pos = 0;
      else if (pos == N) pos = s ? 0 : N;
      else               pos = pos + 1;
      model_valid = 1'b1;
      #1;
      check(tag, step_vec, expect_vec(pos));
      check("R7 onehot", {{(N-1){1'b0}}, ($countones(step_vec) <= 1)}, {{(N-1){1'b0}}, 1'b1});
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
   end

   initial begin
      // R1 reset loads first step; R9 width N gives an N-bit vector
      tick(1, 0, "R1 reset");
      tick(1, 0, "R1 reset hold");
      // R2 shift sequence down to idle, R3 idle hold
      for (int i = 0; i < N; i++) tick(0, 0, "R2 shift");
      for (int i = 0; i < 3; i++) tick(0, 0, "R3 idle hold");
      // R4 start while idle
      tick(0, 1, "R4 start idle");
      // R5 start held through an active pass is ignored, then relaunches
      for (int i = 0; i < 3 * (N + 1); i++) tick(0, 1, "R5 start held");
      tick(0, 0, "R2 shift");
      // start pulse on the step before last, then on the last step
      while (pos != N - 2) tick(0, 0, "R2 shift");
      tick(0, 1, "R5 start early");
      tick(0, 1, "R5 start last");
      tick(0, 1, "R4 start after drain");
      tick(0, 0, "R2 shift");
      // R8 reset with start mid-sequence and while idle
      tick(1, 1, "R8 reset active");
      for (int i = 0; i < N + 2; i++) tick(0, 0, "R3 drain");
      tick(1, 1, "R8 reset idle");
      tick(0, 0, "R2 shift");
      for (int i = 0; i < N + 1; i++) tick(0, 0, "R3 drain");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule